// File: doc/BRIEF.md
# USB Device Address Register and Token Filter

This block holds the device address that a USB function answers to, together with an arming bit that decides whether that address is in force. Software first records the address carried by an address-assignment request while leaving the arming bit low, so the device keeps answering at address 0 through the rest of the control transfer. Once the zero-length status packet has gone out, software sets the arming bit in a second, separate write, and from then on the stored address is the one the device answers to.

The block exports the effective address to the token decoder and compares every incoming token's 7-bit address field against it. A match pulse is produced only while the token-valid strobe is high. The stored address and the arming bit are dropped by a hardware reset, by turning the controller off, and by a detected bus reset. After any of these the effective address returns to 0.

Top module: `usb_devaddr_filter`

## Requirements
- R1: While `rst_n` is low, and after it rises with no write, `rd_addr` is 0, `rd_armed` is 0 and `eff_addr` is 0.
- R2: A write (`wr_en`=1) with `wr_arm`=0 stores `wr_addr` and clears the arming bit at the next clock edge, so `eff_addr` is 0 afterwards.
- R3: A write with `wr_arm`=1 whose `wr_addr` equals the currently stored address sets the arming bit at the next clock edge and leaves the address unchanged.
- R4: A write with `wr_arm`=1 whose `wr_addr` differs from the stored address is ignored: neither the address nor the arming bit changes.
- R5: While `ctrl_on` is 0, the address and the arming bit are cleared at the next clock edge, taking priority over any write in that cycle.
- R6: While `bus_reset` is 1, the address and the arming bit are cleared at the next clock edge, taking priority over any write in that cycle.
- R7: `eff_addr` equals the stored address when the arming bit is 1 and the address is nonzero, and 0 otherwise.
- R8: `tok_hit` is 1 in the same cycle exactly when `tok_valid` is 1 and `tok_addr` equals `eff_addr`.
- R9: `rd_addr` and `rd_armed` show the stored values at all times; with no write and no clear they hold their values from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ctrl_on | input | 1 | Controller enabled; 0 clears the address state |
| bus_reset | input | 1 | Bus reset detected; 1 clears the address state |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | 7 | Address value of the write |
| wr_arm | input | 1 | Arming-bit value of the write |
| rd_addr | output | 7 | Stored address |
| rd_armed | output | 1 | Stored arming bit |
| tok_valid | input | 1 | Token address field is valid this cycle |
| tok_addr | input | 7 | Address field of the incoming token |
| eff_addr | output | 7 | Address the device currently answers to |
| tok_hit | output | 1 | Token targets this device |

## Verification
The hardest case to reach is a write that tries to arm while naming a different address than the one stored, because it needs a stored address first and then a deliberately mismatched second write. The bench reaches it for every one of the 128 addresses by storing the address unarmed, then attempting to arm with a flipped-bit copy, and only then arming properly. It sweeps all 128 token addresses against each armed and unarmed state and rotates through the three clear sources, with a write raised in the same cycle as each bus reset or controller disable.

// File: rtl/usbaddr_pkg.sv
package usbaddr_pkg;

    parameter int ADDR_W = 7;

    typedef logic [ADDR_W-1:0] dev_addr_t;

    typedef struct packed {
        dev_addr_t addr;
        logic      armed;
    } addr_state_t;

    localparam dev_addr_t DEFAULT_ADDR = '0;

endpackage

// File: rtl/usbaddr_regs.sv
module usbaddr_regs
    import usbaddr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_on,
    input  logic      bus_reset,
    input  logic      wr_en,
    input  dev_addr_t wr_addr,
    input  logic      wr_arm,
    output dev_addr_t addr_o,
    output logic      armed_o
);

    addr_state_t state_d;
    addr_state_t state_q;

    logic clear_req;
    logic arm_conflict;

    always_comb begin
        state_d      = state_q;
        clear_req    = !ctrl_on || bus_reset;
        arm_conflict = wr_arm && (wr_addr != state_q.addr);
        if (clear_req) begin
            state_d.addr  = DEFAULT_ADDR;
            state_d.armed = 1'b0;
        end else if (wr_en && !arm_conflict) begin
            state_d.addr  = wr_addr;
            state_d.armed = wr_arm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{addr: DEFAULT_ADDR, armed: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign addr_o  = state_q.addr;
    assign armed_o = state_q.armed;

endmodule

// File: rtl/usbaddr_select.sv
module usbaddr_select
    import usbaddr_pkg::*;
(
    input  dev_addr_t stored_addr,
    input  logic      armed,
    output dev_addr_t eff_addr
);

    logic use_stored;

    always_comb begin
        use_stored = armed && (stored_addr != DEFAULT_ADDR);
        eff_addr   = use_stored ? stored_addr : DEFAULT_ADDR;
    end

endmodule

// File: rtl/usbaddr_match.sv
module usbaddr_match
    import usbaddr_pkg::*;
(
    input  logic      tok_valid,
    input  dev_addr_t tok_addr,
    input  dev_addr_t eff_addr,
    output logic      tok_hit
);

    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff    = tok_addr ^ eff_addr;
        tok_hit = tok_valid && (diff == '0);
    end

endmodule

// File: rtl/usb_devaddr_filter.sv
module usb_devaddr_filter
    import usbaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_on,
    input  logic              bus_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_arm,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_armed,
    input  logic              tok_valid,
    input  logic [ADDR_W-1:0] tok_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              tok_hit
);

    dev_addr_t stored_addr;
    logic      stored_armed;
    dev_addr_t eff_int;

    usbaddr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_on   (ctrl_on),
        .bus_reset (bus_reset),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_arm    (wr_arm),
        .addr_o    (stored_addr),
        .armed_o   (stored_armed)
    );

    usbaddr_select u_select (
        .stored_addr (stored_addr),
        .armed       (stored_armed),
        .eff_addr    (eff_int)
    );

    usbaddr_match u_match (
        .tok_valid (tok_valid),
        .tok_addr  (tok_addr),
        .eff_addr  (eff_int),
        .tok_hit   (tok_hit)
    );

    assign rd_addr  = stored_addr;
    assign rd_armed = stored_armed;
    assign eff_addr = eff_int;

endmodule

// File: rtl/usb_devaddr_filter_chk.sv
module usb_devaddr_filter_chk
    import usbaddr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_on,
    input logic              bus_reset,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_arm,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_armed,
    input logic              tok_valid,
    input logic [ADDR_W-1:0] tok_addr,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              tok_hit
);

    logic quiet;
    assign quiet = ctrl_on && !bus_reset;

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (rd_addr == '0 && !rd_armed && eff_addr == '0)
                else $error("R1 state not cleared in reset");
        end
    end

    assert_store_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && wr_en && !wr_arm) |=> (rd_addr == $past(wr_addr) && !rd_armed));

    assert_arm_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && wr_en && wr_arm && wr_addr == rd_addr) |=> (rd_armed && rd_addr == $past(rd_addr)));

    assert_ignore_mixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && wr_en && wr_arm && wr_addr != rd_addr) |=> ($stable(rd_addr) && $stable(rd_armed)));

    assert_disable_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_on |=> (rd_addr == '0 && !rd_armed));

    assert_busrst_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (rd_addr == '0 && !rd_armed));

    assert_eff_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_armed ? eff_addr == rd_addr : eff_addr == '0));

    assert_token_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tok_hit == (tok_valid && tok_addr == eff_addr));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !wr_en) |=> ($stable(rd_addr) && $stable(rd_armed)));

endmodule

bind usb_devaddr_filter usb_devaddr_filter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_on   (ctrl_on),
    .bus_reset (bus_reset),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_arm    (wr_arm),
    .rd_addr   (rd_addr),
    .rd_armed  (rd_armed),
    .tok_valid (tok_valid),
    .tok_addr  (tok_addr),
    .eff_addr  (eff_addr),
    .tok_hit   (tok_hit)
);

// File: tb/usb_devaddr_filter_tb.sv
module usb_devaddr_filter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 7;
    localparam int NADDR      = 1 << AW;
    localparam int WATCHDOG   = 200000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctrl_on;
    logic          bus_reset;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          wr_arm;
    logic [AW-1:0] rd_addr;
    logic          rd_armed;
    logic          tok_valid;
    logic [AW-1:0] tok_addr;
    logic [AW-1:0] eff_addr;
    logic          tok_hit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_devaddr_filter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_on   (ctrl_on),
        .bus_reset (bus_reset),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_arm    (wr_arm),
        .rd_addr   (rd_addr),
        .rd_armed  (rd_armed),
        .tok_valid (tok_valid),
        .tok_addr  (tok_addr),
        .eff_addr  (eff_addr),
        .tok_hit   (tok_hit)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int a, input int arm);
        int e;
        e = (arm != 0 && a != 0) ? a : 0;
        check({req, " rd_addr"}, int'(rd_addr), a);
        check({req, " rd_armed"}, int'(rd_armed), arm);
        check({req, " eff_addr (R7)"}, int'(eff_addr), e);
    endtask

    // drive at a falling edge, hold through one rising edge, release
    task automatic do_write(input int a, input bit arm);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_arm  = arm;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // exhaustive token sweep against an expected effective address
    task automatic sweep_tokens(input int exp_eff);
        for (int t = 0; t < NADDR; t++) begin
            tok_valid = 1'b1;
            tok_addr  = AW'(t);
            #1;
            check("R8 token hit", int'(tok_hit), (t == exp_eff) ? 1 : 0);
        end
        tok_valid = 1'b0;
        tok_addr  = AW'(exp_eff);
        #1;
        check("R8 no hit without valid", int'(tok_hit), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        ctrl_on   = 1'b1;
        bus_reset = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_arm    = 1'b0;
        tok_valid = 1'b0;
        tok_addr  = '0;
        repeat (2) @(negedge clk);
        check_state("R1 during reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 after reset", 0, 0);
        tok_valid = 1'b1;
        tok_addr  = '0;
        #1;
        check("R1 answers at 0", int'(tok_hit), 1);
        tok_valid = 1'b0;

        for (int a = 0; a < NADDR; a++) begin
            int flip;
            int eff;
            flip = a ^ 'h55;
            eff  = (a != 0) ? a : 0;

            do_write(a, 1'b0);
            check_state("R2 store unarmed", a, 0);
            sweep_tokens(0);

            do_write(flip, 1'b1);
            check_state("R4 mixed write ignored", a, 0);

            do_write(a, 1'b1);
            check_state("R3 arm same address", a, 1);
            sweep_tokens(eff);

            do_write(flip, 1'b1);
            check_state("R4 mixed write ignored while armed", a, 1);

            repeat (2) @(negedge clk);
            check_state("R9 hold idle", a, 1);

            case (a % 3)
                0: begin
                    @(negedge clk);
                    bus_reset = 1'b1;
                    wr_en     = 1'b1;
                    wr_addr   = AW'(flip);
                    wr_arm    = 1'b0;
                    @(negedge clk);
                    bus_reset = 1'b0;
                    wr_en     = 1'b0;
                    check_state("R6 bus reset clears", 0, 0);
                end
                1: begin
                    @(negedge clk);
                    ctrl_on = 1'b0;
                    wr_en   = 1'b1;
                    wr_addr = AW'(flip);
                    wr_arm  = 1'b0;
                    @(negedge clk);
                    ctrl_on = 1'b1;
                    wr_en   = 1'b0;
                    check_state("R5 disable clears", 0, 0);
                end
                default: begin
                    @(negedge clk);
                    rst_n = 1'b0;
                    #1;
                    check_state("R1 hardware reset clears", 0, 0);
                    @(negedge clk);
                    rst_n = 1'b1;
                    @(negedge clk);
                    check_state("R1 after hardware reset", 0, 0);
                end
            endcase
        end

        finish_run();
    end

endmodule